// File: doc/BRIEF.md
# Software-Managed Translation Buffer with Fault Classification

This block is a fully associative translation cache of 64 entries whose contents are managed entirely by software. Each entry pairs a virtual page number and address-space ID with a physical frame number and four flags: non-cacheable, writable (dirty), valid and global. A load, store or fetch presents a 32-bit virtual address on a valid/ready request channel. One cycle later the block returns either the physical address or a fault kind and code on a valid/ready response channel. The fault kind distinguishes a refill miss in the lower (user) half of the address space from a general miss and from a write-protection fault.

Software maintains the entries through five staging registers: index, random, entry-high, entry-low and context. It does so with single-cycle operations: probe for a match, copy an indexed entry out, write an entry at the index register, or write an entry at the hardware-advanced random slot. The random slot never points into the lowest eight entries, so those can hold mappings that must not be evicted. On a user-half refill miss, the context register captures the failing page number next to a software-owned table base. This lets a refill handler build a page-table address without extra arithmetic.

The response channel back-pressures the request channel. A request is accepted only when no response is pending or the pending one is being taken in the same cycle. A pending response holds all its fields until it is taken.

Top module: `tlb_xlate`

## Requirements
- R1: entry-high reads as page number in bits 31:12, address-space ID in bits 11:6 and zero in bits 5:0; entry-low reads as frame number in bits 31:12, non-cacheable bit 11, writable bit 10, valid bit 9, global bit 8 and zero in bits 7:0.
- R2: An entry matches a lookup when its page number equals address bits 31:12 and either its global flag is set or its ID equals the ID in entry-high. A hit on a valid entry that is not a protection fault returns kind 0, code 0, physical address {frame, address bits 11:0}, and the entry's non-cacheable flag on rsp_nc. Any fault returns address 0 and rsp_nc 0.
- R3: When several entries match, the lowest-numbered one is used, for lookups and for probes.
- R4: With no match and address bit 31 clear, the response is kind 1 (refill). The code is 3 for a store (req_acc 1) and 2 for a load (req_acc 0) or a fetch (req_acc 2). This holds whatever mode the requester runs in.
- R5: With no match and address bit 31 set, or with a match whose valid flag is clear, the response is kind 2 (general miss), code 3 for a store and 2 otherwise.
- R6: A store that hits a valid entry whose writable flag is clear returns kind 3, code 1. A load of the same page returns a normal hit.
- R7: req_ready equals (not rsp_valid) or rsp_ready. An accepted request produces rsp_valid in the next cycle. While rsp_valid is high and rsp_ready low, every response field holds.
- R8: Probe (op_kind 0) compares entry-high against all entries. On a match, index bit 31 is cleared and bits 13:8 take the entry number. Otherwise bit 31 is set and bits 13:8 keep their value.
- R9: Indexed read (op_kind 1) copies the entry named by index bits 13:8 into entry-high and entry-low, visible after one clock.
- R10: Indexed write (op_kind 2) stores entry-high and entry-low into the entry named by index bits 13:8. Random write (op_kind 3) stores them into the entry named by random bits 13:8.
- R11: The random register reads its slot in bits 13:8. It resets to 63, decreases by one every clock, goes from 8 back to 63, and never holds 0 to 7.
- R12: A user-half refill miss loads context bits 20:2 with address bits 30:12. Context bits 31:21 change only by software write, and bits 1:0 read zero.
- R13: Software writes select a register with sw_sel (0 index: bits 31 and 13:8; 1 entry-high; 2 entry-low; 3 context base). A software write in a cycle with op_valid high has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Lookup request present |
| req_ready | output | 1 | Lookup request can be taken |
| req_vaddr | input | 32 | Virtual address to translate |
| req_acc | input | 2 | Access type: 0 load, 1 store, 2 fetch |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Response taken by consumer |
| rsp_paddr | output | 32 | Physical address, zero on a fault |
| rsp_nc | output | 1 | Non-cacheable flag of the hit entry |
| rsp_kind | output | 2 | 0 none, 1 refill, 2 general miss, 3 protection |
| rsp_code | output | 4 | Fault code: 0, 1, 2 or 3 |
| op_valid | input | 1 | Maintenance operation strobe |
| op_kind | input | 2 | 0 probe, 1 read, 2 indexed write, 3 random write |
| sw_we | input | 1 | Software register write strobe |
| sw_sel | input | 2 | Register chosen for the write |
| sw_wdata | input | 32 | Write data |
| index_q | output | 32 | Index register |
| random_q | output | 32 | Random register |
| entryhi_q | output | 32 | Entry-high staging register |
| entrylo_q | output | 32 | Entry-low staging register |
| context_q | output | 32 | Context register |

## Verification
The entry array has no port of its own, so a corrupted entry stays hidden until a lookup, probe or indexed read touches it. The bench therefore reaches each stored entry through at least two of those paths soon after writing it. A wrong random counter shows on random_q within one clock, and it also steers a random write into the wrong slot, which later shows as a wrong probe index. A wrong staging or response register shows at the negative edge that follows the clock that should have loaded it. The reference model compares every visible register on every cycle, so such a fault is caught no later than one clock after it appears.

// File: rtl/tlb_pkg.sv
package tlb_pkg;

  typedef struct packed {
    logic [19:0] vpn;
    logic [5:0]  asid;
    logic [19:0] pfn;
    logic        nc;
    logic        d;
    logic        v;
    logic        g;
  } tlb_ent_t;

  typedef enum logic [1:0] {
    FK_NONE   = 2'd0,
    FK_REFILL = 2'd1,
    FK_MISS   = 2'd2,
    FK_PROT   = 2'd3
  } fault_e;

  typedef enum logic [1:0] {
    OP_PROBE  = 2'd0,
    OP_READ   = 2'd1,
    OP_WR_IDX = 2'd2,
    OP_WR_RND = 2'd3
  } op_e;

  typedef enum logic [1:0] {
    SEL_INDEX = 2'd0,
    SEL_EHI   = 2'd1,
    SEL_ELO   = 2'd2,
    SEL_CTX   = 2'd3
  } sel_e;

  localparam logic [1:0] ACC_STORE   = 2'd1;
  localparam logic [3:0] CODE_NONE   = 4'd0;
  localparam logic [3:0] CODE_PROT   = 4'd1;
  localparam logic [3:0] CODE_MISS_L = 4'd2;
  localparam logic [3:0] CODE_MISS_S = 4'd3;

endpackage

// File: rtl/tlb_match.sv
// Associative compare of every entry against one key, lowest index wins.
module tlb_match #(
  parameter int N  = 64,
  parameter int IW = 6
) (
  input  logic [N-1:0][19:0] vpns,
  input  logic [N-1:0][5:0]  asids,
  input  logic [N-1:0]       globs,
  input  logic [19:0]        key_vpn,
  input  logic [5:0]         key_asid,
  output logic               hit,
  output logic [IW-1:0]      idx
);
  logic [N-1:0] m;

  for (genvar i = 0; i < N; i++) begin : g_cmp
    assign m[i] = (vpns[i] == key_vpn) && (globs[i] || (asids[i] == key_asid));
  end

  always_comb begin
    hit = |m;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (m[i]) idx = IW'(i);
    end
  end
endmodule

// File: rtl/tlb_rand.sv
// Replacement pointer: counts down each clock, skips the reserved low slots.
module tlb_rand #(
  parameter int N   = 64,
  parameter int RSV = 8,
  parameter int IW  = 6
) (
  input  logic          clk,
  input  logic          rst,
  output logic [IW-1:0] rnd
);
  localparam logic [IW-1:0] TOP   = IW'(N - 1);
  localparam logic [IW-1:0] FLOOR = IW'(RSV);

  always_ff @(posedge clk) begin
    if (rst)               rnd <= TOP;
    else if (rnd == FLOOR) rnd <= TOP;
    else                   rnd <= rnd - 1'b1;
  end
endmodule

// File: rtl/tlb_classify.sv
// Turns match outcome and access type into a fault kind and code.
module tlb_classify
  import tlb_pkg::*;
(
  input  logic       hit,
  input  logic       valid,
  input  logic       dirty,
  input  logic       is_store,
  input  logic       upper_half,
  output fault_e     kind,
  output logic [3:0] code
);
  logic [3:0] miss_code;
  assign miss_code = is_store ? CODE_MISS_S : CODE_MISS_L;

  always_comb begin
    if (!hit) begin
      kind = upper_half ? FK_MISS : FK_REFILL;
      code = miss_code;
    end else if (!valid) begin
      kind = FK_MISS;
      code = miss_code;
    end else if (is_store && !dirty) begin
      kind = FK_PROT;
      code = CODE_PROT;
    end else begin
      kind = FK_NONE;
      code = CODE_NONE;
    end
  end
endmodule

// File: rtl/tlb_store.sv
// Entry array with one write port; contents are exposed for parallel compare.
module tlb_store
  import tlb_pkg::*;
#(
  parameter int N  = 64,
  parameter int IW = 6
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                we,
  input  logic [IW-1:0]       waddr,
  input  tlb_ent_t            wdata,
  output tlb_ent_t [N-1:0]    ents
);
  always_ff @(posedge clk) begin
    if (rst)     ents <= '0;
    else if (we) ents[waddr] <= wdata;
  end
endmodule

// File: rtl/tlb_xlate.sv
module tlb_xlate
  import tlb_pkg::*;
#(
  parameter int ENTRIES = 64,
  parameter int RSV     = 8
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic [31:0] req_vaddr,
  input  logic [1:0]  req_acc,
  output logic        rsp_valid,
  input  logic        rsp_ready,
  output logic [31:0] rsp_paddr,
  output logic        rsp_nc,
  output logic [1:0]  rsp_kind,
  output logic [3:0]  rsp_code,
  input  logic        op_valid,
  input  logic [1:0]  op_kind,
  input  logic        sw_we,
  input  logic [1:0]  sw_sel,
  input  logic [31:0] sw_wdata,
  output logic [31:0] index_q,
  output logic [31:0] random_q,
  output logic [31:0] entryhi_q,
  output logic [31:0] entrylo_q,
  output logic [31:0] context_q
);
  localparam int IW = $clog2(ENTRIES);

  tlb_ent_t [ENTRIES-1:0] ents;
  logic [ENTRIES-1:0][19:0] vpns;
  logic [ENTRIES-1:0][5:0]  asids;
  logic [ENTRIES-1:0]       globs;

  logic          idx_p;
  logic [IW-1:0] idx_f;
  logic [IW-1:0] rnd;
  logic [19:0]   ehi_vpn;
  logic [5:0]    ehi_asid;
  logic [19:0]   elo_pfn;
  logic [3:0]    elo_fl;   // {nc, d, v, g}
  logic [10:0]   ctx_base;
  logic [18:0]   ctx_bad;

  logic          lk_hit, pr_hit;
  logic [IW-1:0] lk_idx, pr_idx;
  tlb_ent_t      lk_ent, rd_ent, wr_ent;
  fault_e        cls_kind;
  logic [3:0]    cls_code;
  logic          accept;
  logic          st_we;
  logic [IW-1:0] st_addr;
  logic          sw_unused;

  for (genvar i = 0; i < ENTRIES; i++) begin : g_keys
    assign vpns[i]  = ents[i].vpn;
    assign asids[i] = ents[i].asid;
    assign globs[i] = ents[i].g;
  end

  tlb_store #(.N(ENTRIES), .IW(IW)) u_store (
    .clk(clk), .rst(rst), .we(st_we), .waddr(st_addr), .wdata(wr_ent), .ents(ents)
  );

  tlb_match #(.N(ENTRIES), .IW(IW)) u_lookup (
    .vpns(vpns), .asids(asids), .globs(globs),
    .key_vpn(req_vaddr[31:12]), .key_asid(ehi_asid),
    .hit(lk_hit), .idx(lk_idx)
  );

  tlb_match #(.N(ENTRIES), .IW(IW)) u_probe (
    .vpns(vpns), .asids(asids), .globs(globs),
    .key_vpn(ehi_vpn), .key_asid(ehi_asid),
    .hit(pr_hit), .idx(pr_idx)
  );

  tlb_rand #(.N(ENTRIES), .RSV(RSV), .IW(IW)) u_rand (
    .clk(clk), .rst(rst), .rnd(rnd)
  );

  assign lk_ent = ents[lk_idx];
  assign rd_ent = ents[idx_f];

  tlb_classify u_cls (
    .hit(lk_hit), .valid(lk_ent.v), .dirty(lk_ent.d),
    .is_store(req_acc == ACC_STORE), .upper_half(req_vaddr[31]),
    .kind(cls_kind), .code(cls_code)
  );

  // staging words into an entry image
  always_comb begin
    wr_ent.vpn  = ehi_vpn;
    wr_ent.asid = ehi_asid;
    wr_ent.pfn  = elo_pfn;
    {wr_ent.nc, wr_ent.d, wr_ent.v, wr_ent.g} = elo_fl;
  end

  assign st_we   = op_valid && ((op_e'(op_kind) == OP_WR_IDX) || (op_e'(op_kind) == OP_WR_RND));
  assign st_addr = (op_e'(op_kind) == OP_WR_RND) ? rnd : idx_f;

  // request / response channel
  assign req_ready = !rsp_valid || rsp_ready;
  assign accept    = req_valid && req_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_paddr <= '0;
      rsp_nc    <= 1'b0;
      rsp_kind  <= FK_NONE;
      rsp_code  <= CODE_NONE;
    end else if (accept) begin
      rsp_valid <= 1'b1;
      rsp_kind  <= cls_kind;
      rsp_code  <= cls_code;
      rsp_paddr <= (cls_kind == FK_NONE) ? {lk_ent.pfn, req_vaddr[11:0]} : '0;
      rsp_nc    <= (cls_kind == FK_NONE) && lk_ent.nc;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

  // staging registers: operations take precedence over software writes
  always_ff @(posedge clk) begin
    if (rst) begin
      idx_p    <= 1'b0;
      idx_f    <= '0;
      ehi_vpn  <= '0;
      ehi_asid <= '0;
      elo_pfn  <= '0;
      elo_fl   <= '0;
      ctx_base <= '0;
      ctx_bad  <= '0;
    end else begin
      if (accept && (cls_kind == FK_REFILL)) ctx_bad <= req_vaddr[30:12];
      if (op_valid) begin
        case (op_e'(op_kind))
          OP_PROBE: begin
            if (pr_hit) begin
              idx_p <= 1'b0;
              idx_f <= pr_idx;
            end else begin
              idx_p <= 1'b1;
            end
          end
          OP_READ: begin
            ehi_vpn  <= rd_ent.vpn;
            ehi_asid <= rd_ent.asid;
            elo_pfn  <= rd_ent.pfn;
            elo_fl   <= {rd_ent.nc, rd_ent.d, rd_ent.v, rd_ent.g};
          end
          default: ;
        endcase
      end else if (sw_we) begin
        case (sel_e'(sw_sel))
          SEL_INDEX: begin
            idx_p <= sw_wdata[31];
            idx_f <= sw_wdata[8 +: IW];
          end
          SEL_EHI: begin
            ehi_vpn  <= sw_wdata[31:12];
            ehi_asid <= sw_wdata[11:6];
          end
          SEL_ELO: begin
            elo_pfn <= sw_wdata[31:12];
            elo_fl  <= sw_wdata[11:8];
          end
          default: ctx_base <= sw_wdata[31:21];
        endcase
      end
    end
  end

  assign sw_unused = ^sw_wdata[5:0];

  always_comb begin
    index_q              = '0;
    index_q[31]          = idx_p;
    index_q[8 +: IW]     = idx_f;
    random_q             = '0;
    random_q[8 +: IW]    = rnd;
  end

  assign entryhi_q = {ehi_vpn, ehi_asid, 6'b0};
  assign entrylo_q = {elo_pfn, elo_fl, 8'b0};
  assign context_q = {ctx_base, ctx_bad, 2'b0};

endmodule

// File: rtl/tlb_xlate_chk.sv
module tlb_xlate_chk (
  input logic        clk,
  input logic        rst,
  input logic        req_valid,
  input logic        req_ready,
  input logic        rsp_valid,
  input logic        rsp_ready,
  input logic [31:0] rsp_paddr,
  input logic [1:0]  rsp_kind,
  input logic [3:0]  rsp_code,
  input logic [31:0] random_q,
  input logic [31:0] entryhi_q,
  input logic [31:0] entrylo_q
);
  // R11
  rand_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (random_q[13:8] == 6'd8) |=> (random_q[13:8] == 6'd63));

  // R11
  rand_step_chk: assert property (@(posedge clk) disable iff (rst)
    (random_q[13:8] != 6'd8) |=> (random_q[13:8] == $past(random_q[13:8]) - 6'd1));

  // R7
  rsp_issue_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> rsp_valid);

  // R7
  rsp_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_paddr) &&
                                   $stable(rsp_kind) && $stable(rsp_code)));

  // R6
  prot_code_chk: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_kind == 2'd3) |-> (rsp_code == 4'd1));

  // R4
  refill_code_chk: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_kind == 2'd1) |-> ((rsp_code == 4'd2 || rsp_code == 4'd3) && rsp_paddr == 32'd0));

  // R1
  stage_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (entryhi_q[5:0] == 6'd0) && (entrylo_q[7:0] == 8'd0));
endmodule

bind tlb_xlate tlb_xlate_chk u_chk (.*);

// File: tb/sim_tlb_xlate.sv
module sim_tlb_xlate;
  logic        clk = 1'b0;
  logic        rst;
  logic        req_valid, req_ready, rsp_valid, rsp_ready, rsp_nc;
  logic [31:0] req_vaddr, rsp_paddr;
  logic [1:0]  req_acc, rsp_kind, op_kind, sw_sel;
  logic [3:0]  rsp_code;
  logic        op_valid, sw_we;
  logic [31:0] sw_wdata, index_q, random_q, entryhi_q, entrylo_q, context_q;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #10 clk = ~clk;

  tlb_xlate u0 (.*);

  // ---------------- behavioural reference ----------------
  logic [19:0] mvpn [64];
  logic [5:0]  masid[64];
  logic [19:0] mpfn [64];
  logic [3:0]  mfl  [64];   // nc d v g
  bit          m_ip;
  int          m_if, m_rnd;
  logic [19:0] m_ehv, m_elp;
  logic [5:0]  m_eha;
  logic [3:0]  m_elf;
  logic [10:0] m_cb;
  logic [18:0] m_cbad;
  bit          m_rv, m_nc;
  logic [31:0] m_pa;
  int          m_kind, m_code;

  function automatic int find(logic [19:0] vpn, logic [5:0] asid);
    for (int i = 0; i < 64; i++)
      if (mvpn[i] == vpn && (mfl[i][0] || masid[i] == asid)) return i;
    return -1;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < 64; i++) begin
        mvpn[i] = '0; masid[i] = '0; mpfn[i] = '0; mfl[i] = '0;
      end
      m_ip = 0; m_if = 0; m_rnd = 63;
      m_ehv = '0; m_eha = '0; m_elp = '0; m_elf = '0; m_cb = '0; m_cbad = '0;
      m_rv = 0; m_nc = 0; m_pa = '0; m_kind = 0; m_code = 0;
    end else begin
      int hit;
      int nxt_rnd;
      bit st;
      nxt_rnd = (m_rnd == 8) ? 63 : m_rnd - 1;
      if (req_valid && (!m_rv || rsp_ready)) begin
        st  = (req_acc == 2'd1);
        hit = find(req_vaddr[31:12], m_eha);
        m_rv = 1;
        if (hit < 0) begin
          m_kind = req_vaddr[31] ? 2 : 1;
          m_code = st ? 3 : 2;
        end else if (!mfl[hit][1]) begin
          m_kind = 2; m_code = st ? 3 : 2;
        end else if (st && !mfl[hit][2]) begin
          m_kind = 3; m_code = 1;
        end else begin
          m_kind = 0; m_code = 0;
        end
        m_pa = (m_kind == 0) ? {mpfn[hit], req_vaddr[11:0]} : 32'd0;
        m_nc = (m_kind == 0) ? mfl[hit][3] : 1'b0;
        if (m_kind == 1) m_cbad = req_vaddr[30:12];
      end else if (rsp_ready) begin
        m_rv = 0;
      end
      if (op_valid) begin
        case (op_kind)
          2'd0: begin
            hit = find(m_ehv, m_eha);
            if (hit >= 0) begin m_ip = 0; m_if = hit; end
            else m_ip = 1;
          end
          2'd1: begin
            m_ehv = mvpn[m_if]; m_eha = masid[m_if];
            m_elp = mpfn[m_if]; m_elf = mfl[m_if];
          end
          default: begin
            hit = (op_kind == 2'd3) ? m_rnd : m_if;
            mvpn[hit] = m_ehv; masid[hit] = m_eha;
            mpfn[hit] = m_elp; mfl[hit] = m_elf;
          end
        endcase
      end else if (sw_we) begin
        case (sw_sel)
          2'd0: begin m_ip = sw_wdata[31]; m_if = int'(sw_wdata[13:8]); end
          2'd1: begin m_ehv = sw_wdata[31:12]; m_eha = sw_wdata[11:6]; end
          2'd2: begin m_elp = sw_wdata[31:12]; m_elf = sw_wdata[11:8]; end
          default: m_cb = sw_wdata[31:21];
        endcase
      end
      m_rnd = nxt_rnd;
    end
  end

  // ---------------- checking ----------------
  task automatic cmp(string tag, string what, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic compare_all();
    cmp("R7",  "rsp_valid", 32'(rsp_valid), 32'(m_rv));
    cmp("R7",  "req_ready", 32'(req_ready), 32'(!m_rv || rsp_ready));
    cmp("R2",  "rsp_paddr", rsp_paddr, m_pa);
    cmp("R2",  "rsp_nc",    32'(rsp_nc), 32'(m_nc));
    cmp("R5",  "rsp_kind",  32'(rsp_kind), 32'(m_kind));
    cmp("R5",  "rsp_code",  32'(rsp_code), 32'(m_code));
    cmp("R8",  "index",     index_q, {m_ip, 17'd0, 6'(m_if), 8'd0});
    cmp("R11", "random",    random_q, {18'd0, 6'(m_rnd), 8'd0});
    cmp("R9",  "entryhi",   entryhi_q, {m_ehv, m_eha, 6'd0});
    cmp("R9",  "entrylo",   entrylo_q, {m_elp, m_elf, 8'd0});
    cmp("R12", "context",   context_q, {m_cb, m_cbad, 2'd0});
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    compare_all();
  endtask

  task automatic sw(logic [1:0] sel, logic [31:0] d);
    sw_we = 1; sw_sel = sel; sw_wdata = d;
    tick();
    sw_we = 0;
  endtask

  task automatic op(logic [1:0] k);
    op_valid = 1; op_kind = k;
    tick();
    op_valid = 0;
  endtask

  task automatic put(int idx, logic [19:0] vpn, logic [5:0] asid, logic [19:0] pfn, logic [3:0] fl);
    sw(2'd1, {vpn, asid, 6'd0});
    sw(2'd2, {pfn, fl, 8'd0});
    sw(2'd0, {18'd0, 6'(idx), 8'd0});
    op(2'd2);
  endtask

  task automatic look(logic [31:0] va, logic [1:0] acc);
    req_valid = 1; req_vaddr = va; req_acc = acc;
    tick();
    req_valid = 0;
  endtask

  initial begin
    rst = 1; rsp_ready = 1; req_valid = 0; req_vaddr = '0; req_acc = '0;
    op_valid = 0; op_kind = '0; sw_we = 0; sw_sel = '0; sw_wdata = '0;
    repeat (3) tick();
    // R11 reset value, reset state of staging and response
    cmp("R11", "random at reset", random_q, 32'h0000_3F00);
    cmp("R8",  "index at reset",  index_q,  32'h0);
    cmp("R7",  "rsp_valid at reset", 32'(rsp_valid), 32'd0);
    rst = 0;
    tick();
    cmp("R11", "random after first clock", random_q, 32'h0000_3E00);

    // R10 indexed writes
    put(5,  20'h00010, 6'd3, 20'hABCDE, 4'b0110);
    put(9,  20'h00010, 6'd3, 20'h11111, 4'b0110);
    put(12, 20'h80005, 6'd0, 20'h0F00D, 4'b1011);
    put(20, 20'h00020, 6'd3, 20'h33333, 4'b0100);
    put(30, 20'h00030, 6'd7, 20'h44444, 4'b0110);
    sw(2'd1, {20'h00000, 6'd3, 6'd0});

    // R2 R3: duplicate match, lowest entry wins
    look(32'h0001_0ABC, 2'd0);
    cmp("R3", "paddr lowest match", rsp_paddr, 32'hABCD_EABC);
    cmp("R2", "kind on hit", 32'(rsp_kind), 32'd0);
    // R5: match with valid clear
    look(32'h0002_0004, 2'd1);
    cmp("R5", "invalid entry kind", 32'(rsp_kind), 32'd2);
    cmp("R5", "invalid entry store code", 32'(rsp_code), 32'd3);
    // R4 R12: ID mismatch in lower half
    look(32'h0003_0123, 2'd2);
    cmp("R4", "refill kind", 32'(rsp_kind), 32'd1);
    cmp("R4", "refill fetch code", 32'(rsp_code), 32'd2);
    cmp("R12", "bad page captured", context_q, 32'h0000_00C0);
    // R2: global entry, non-cacheable
    look(32'h8000_5010, 2'd0);
    cmp("R2", "global hit paddr", rsp_paddr, 32'h0F00_D010);
    cmp("R2", "nc flag", 32'(rsp_nc), 32'd1);
    // R6: store to read-only page
    look(32'h8000_5010, 2'd1);
    cmp("R6", "prot kind", 32'(rsp_kind), 32'd3);
    cmp("R6", "prot code", 32'(rsp_code), 32'd1);
    // R5: upper half, nothing matches
    look(32'h9000_0000, 2'd0);
    cmp("R5", "upper miss kind", 32'(rsp_kind), 32'd2);
    // R4: lower half store miss
    look(32'h1234_5000, 2'd1);
    cmp("R4", "refill store code", 32'(rsp_code), 32'd3);
    cmp("R12", "bad page second", context_q, 32'h0004_8D14);
    // R12: software writes only the base
    sw(2'd3, 32'hFFFF_FFFF);
    cmp("R12", "context base write", context_q, 32'hFFE4_8D14);

    // R7: back-pressure
    rsp_ready = 0;
    look(32'h0001_0ABC, 2'd0);
    req_valid = 1; req_vaddr = 32'h9000_0000; req_acc = 2'd0;
    tick();
    cmp("R7", "held paddr", rsp_paddr, 32'hABCD_EABC);
    cmp("R7", "ready low while held", 32'(req_ready), 32'd0);
    rsp_ready = 1;
    tick();
    req_valid = 0;
    cmp("R7", "next response after release", 32'(rsp_kind), 32'd2);
    tick();
    cmp("R7", "valid drops when taken", 32'(rsp_valid), 32'd0);

    // R8: probe hit, then probe miss keeps field
    sw(2'd1, {20'h00010, 6'd3, 6'd0});
    op(2'd0);
    cmp("R8", "probe hit index", index_q, 32'h0000_0500);
    sw(2'd1, {20'h77777, 6'd3, 6'd0});
    op(2'd0);
    cmp("R8", "probe miss index", index_q, 32'h8000_0500);

    // R9: indexed read
    sw(2'd0, 32'h0000_0C00);
    op(2'd1);
    cmp("R9", "read entryhi", entryhi_q, 32'h8000_5000);
    cmp("R9", "read entrylo", entrylo_q, 32'h0F00_DB00);

    // R13: software write ignored alongside an operation
    sw_we = 1; sw_sel = 2'd2; sw_wdata = 32'hFFFF_FFFF;
    op(2'd0);
    sw_we = 0;
    cmp("R13", "entrylo untouched", entrylo_q, 32'h0F00_DB00);
    cmp("R3", "probe global hit", index_q, 32'h0000_0C00);

    // R1: low bits of staging registers read zero
    sw(2'd1, 32'h0003_F0FF);
    cmp("R1", "entryhi format", entryhi_q, 32'h0003_F0C0);
    sw(2'd2, 32'h1234_56FF);
    cmp("R1", "entrylo format", entrylo_q, 32'h1234_5600);

    // R10: random-slot write then find it again
    sw(2'd1, {20'h00040, 6'd3, 6'd0});
    sw(2'd2, {20'h22222, 4'b0110, 8'd0});
    op(2'd3);
    look(32'h0004_0008, 2'd0);
    cmp("R10", "random write lookup", rsp_paddr, 32'h2222_2008);
    op(2'd0);
    cmp("R10", "random slot above reserved", 32'(index_q[13:8] >= 6'd8), 32'd1);

    // R11: let the pointer wrap more than once
    repeat (130) tick();
    cmp("R11", "random never reserved", 32'(random_q[13:8] >= 6'd8), 32'd1);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL R7 watchdog actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule